// File: doc/BRIEF.md
# Multiply / Divide Unit with Divide-Error Trap

This block is the integer multiply and divide engine of an accumulator-style processor core. A single-cycle start request carries an operation code, a size bit, the accumulator pair and a source operand. The unit captures them and runs a shift-add multiplier and a restoring shift-subtract divider for a fixed number of steps. It then presents the new accumulator halves and the carry and overflow flags, along with a one-cycle completion pulse. When a quotient cannot be represented in its destination, or the divisor is zero, the unit does not produce results. It raises a divide-error trap request in the same cycle as the completion pulse, and the core's exception logic takes over from there.

The two decimal-adjust operations reuse the same datapath. Split-to-digits uses the divider with a constant divisor of ten. Join-from-digits uses the multiplier with a constant multiplier of ten and then adds the low byte.

The controller is a five-state machine. ST_IDLE waits for an accepted start and moves to ST_PREP. ST_PREP loads the sign-conditioned magnitudes into both arithmetic units and always moves to ST_RUN. ST_RUN steps the units once per cycle and moves to ST_FIX after the last step for the size in use. ST_FIX applies signs, checks the quotient range and registers the results, then always moves to ST_DONE. ST_DONE drives the completion pulse for one cycle and always returns to ST_IDLE.

Top module: `mdu_trap_unit`

## Requirements
- R1: After reset, `res_ax`, `res_dx`, `flag_cf`, `flag_of`, `done` and `trap` are all 0.
- R2: `op_sel` codes are as follows: 0 is unsigned multiply, 1 is signed multiply, 2 is unsigned divide, 3 is signed divide, 4 is split-to-digits and 5 is join-from-digits. A start is accepted only in ST_IDLE with a code from 0 to 5. A start carrying code 6 or 7 is ignored: no `done` follows and the outputs keep their values.
- R3: Multiplies and divides with `wide`=1 run word size and take 16 steps. All other operations run byte size and take 8 steps. `done` is high for exactly one cycle, beginning steps+2 rising edges after the edge that samples the start.
- R4: Byte multiply sets `res_ax` to `ax_in[7:0]` times `src_in[7:0]`, with both read as two's complement for code 1. `res_dx` equals the captured `dx_in`.
- R5: Word multiply sets {`res_dx`,`res_ax`} to `ax_in` times `src_in`, with both read as two's complement for code 1.
- R6: After a multiply, `flag_cf` and `flag_of` are both 1 when the upper half of the product is significant and both 0 otherwise. For code 0, significant means non-zero. For code 1, significant means not a sign copy of the lower half's top bit.
- R7: Byte divide divides `ax_in` by `src_in[7:0]`. The quotient goes to `res_ax[7:0]` and the remainder to `res_ax[15:8]`. `res_dx` equals the captured `dx_in`. Every divide that completes without a trap clears both flags.
- R8: Word divide divides {`dx_in`,`ax_in`} by `src_in`. The quotient goes to `res_ax` and the remainder to `res_dx`.
- R9: Signed divide truncates the quotient toward zero. The remainder takes the sign of the dividend.
- R10: A zero divisor, or an unsigned quotient that does not fit the destination size, raises `trap` together with `done`. In that case `res_ax` and `res_dx` equal the captured `ax_in` and `dx_in`, and both flags are 0.
- R11: A signed quotient whose magnitude exceeds 127 at byte size, or 32767 at word size, traps as in R10. A quotient of -128 or -32768 therefore traps.
- R12: Split-to-digits sets `res_ax[15:8]` to `ax_in[7:0]`/10 and `res_ax[7:0]` to the remainder. Both flags are cleared.
- R13: Join-from-digits sets `res_ax[7:0]` to (`ax_in[15:8]`*10 + `ax_in[7:0]`) mod 256 and `res_ax[15:8]` to 0. `src_in` has no effect and both flags are cleared.
- R14: While an operation is in progress, including its `done` cycle, `start` and input changes are ignored. Results hold their values between completions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Single-cycle operation request |
| op_sel | input | 3 | Operation code (see R2) |
| wide | input | 1 | 1 = word size for multiply/divide, 0 = byte size |
| ax_in | input | 16 | Accumulator low word |
| dx_in | input | 16 | Accumulator high word / extension |
| src_in | input | 16 | Source operand |
| res_ax | output | 16 | New accumulator low word |
| res_dx | output | 16 | New accumulator high word |
| flag_cf | output | 1 | Carry flag result |
| flag_of | output | 1 | Overflow flag result |
| done | output | 1 | One-cycle completion pulse |
| trap | output | 1 | Divide-error trap request, only with `done` |

## Verification
Two events can share a cycle. The completion pulse can coincide with a fresh start request, which must be ignored. The trap request can coincide with the completion pulse. The bench raises `start` in the exact cycle in which `done` is high. It then watches the ports for many cycles, expecting no second completion and unchanged results. The trap is judged in the done cycle itself, where it is compared with a trap decision computed from integer arithmetic. The tests include divides at the edges of the signed range (-127 against -128, and -32767 against -32768), zero divisors, and quotients one step past the unsigned limit. A start pulse part-way through a run, and inputs scrambled every busy cycle, must not disturb the result of the operation in flight.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
    typedef enum logic [2:0] {
        OP_MULU = 3'd0,
        OP_MULS = 3'd1,
        OP_DIVU = 3'd2,
        OP_DIVS = 3'd3,
        OP_AAM  = 3'd4,
        OP_AAD  = 3'd5
    } md_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREP,
        ST_RUN,
        ST_FIX,
        ST_DONE
    } md_state_e;
endpackage

// File: rtl/mdu_shift_mul.sv
module mdu_shift_mul #(
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           step,
    input  logic [W-1:0]   mcand,
    input  logic [W-1:0]   mplier,
    output logic [2*W-1:0] product
);
    timeunit 1ns; timeprecision 1ps;

    logic [2*W-1:0] acc_q;
    logic [2*W-1:0] mc_q;
    logic [W-1:0]   mp_q;

    // one multiplier bit per step: add the shifted multiplicand when set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            mc_q  <= '0;
            mp_q  <= '0;
        end else if (load) begin
            acc_q <= '0;
            mc_q  <= {{W{1'b0}}, mcand};
            mp_q  <= mplier;
        end else if (step) begin
            if (mp_q[0]) acc_q <= acc_q + mc_q;
            mc_q <= mc_q << 1;
            mp_q <= mp_q >> 1;
        end
    end

    assign product = acc_q;
endmodule

// File: rtl/mdu_shift_div.sv
module mdu_shift_div #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] num_hi,
    input  logic [W-1:0] num_lo,
    input  logic [W-1:0] den,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem
);
    timeunit 1ns; timeprecision 1ps;

    logic [W-1:0] r_q;
    logic [W-1:0] q_q;
    logic [W:0]   trial;
    logic [W:0]   diff;
    logic         fits;

    always_comb begin
        trial = {r_q, q_q[W-1]};
        diff  = trial - {1'b0, den};
        fits  = trial >= {1'b0, den};
    end

    // restoring division: bring in one dividend bit, subtract if it fits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
            q_q <= '0;
        end else if (load) begin
            r_q <= num_hi;
            q_q <= num_lo;
        end else if (step) begin
            r_q <= fits ? diff[W-1:0] : trial[W-1:0];
            q_q <= {q_q[W-2:0], fits};
        end
    end

    assign quo = q_q;
    assign rem = r_q;
endmodule

// File: rtl/mdu_trap_unit.sv
module mdu_trap_unit
    import mdu_pkg::*;
#(
    parameter int DW    = 16,
    parameter int RADIX = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [2:0]    op_sel,
    input  logic          wide,
    input  logic [DW-1:0] ax_in,
    input  logic [DW-1:0] dx_in,
    input  logic [DW-1:0] src_in,
    output logic [DW-1:0] res_ax,
    output logic [DW-1:0] res_dx,
    output logic          flag_cf,
    output logic          flag_of,
    output logic          done,
    output logic          trap
);
    timeunit 1ns; timeprecision 1ps;

    localparam int HW = DW / 2;
    localparam int PW = 2 * DW;
    localparam int CW = $clog2(DW + 1);

    md_state_e     state_q, state_d;
    md_op_e        op_q;
    logic          wide_q;
    logic [DW-1:0] ax_q, dx_q, src_q;
    logic [CW-1:0] cnt_q, run_len;
    logic          accept, trap_q;

    logic          is_signed, is_aam, is_aad, is_div, eff_wide;
    logic [DW-1:0] a_ext, s_ext, a_mag, s_mag;
    logic          a_neg, s_neg, n_neg, pre_ovf;
    logic [PW-1:0] n_ext, n_mag;
    logic [DW-1:0] div_hi, div_lo, div_den, mul_a, mul_b;
    logic [PW-1:0] prod_mag, p_val;
    logic [DW-1:0] quo_mag, rem_mag, q_val, r_val, q_lim;
    logic [HW-1:0] aad_sum;
    logic          mul_big, div_trap;
    logic [DW-1:0] nx_ax, nx_dx;
    logic          nx_flag, nx_trap;

    assign accept   = (state_q == ST_IDLE) && start && (op_sel <= 3'(OP_AAD));
    assign is_signed = (op_q == OP_MULS) || (op_q == OP_DIVS);
    assign is_aam   = (op_q == OP_AAM);
    assign is_aad   = (op_q == OP_AAD);
    assign is_div   = (op_q == OP_DIVU) || (op_q == OP_DIVS);
    assign eff_wide = wide_q && !is_aam && !is_aad;
    assign run_len  = eff_wide ? CW'(DW) : CW'(HW);

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = ST_PREP;
            ST_PREP: state_d = ST_RUN;
            ST_RUN:  if (cnt_q == run_len - CW'(1)) state_d = ST_FIX;
            ST_FIX:  state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // ---------------- operand capture and step counter ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= OP_MULU;
            wide_q <= 1'b0;
            ax_q   <= '0;
            dx_q   <= '0;
            src_q  <= '0;
            cnt_q  <= '0;
        end else begin
            if (accept) begin
                op_q   <= md_op_e'(op_sel);
                wide_q <= wide;
                ax_q   <= ax_in;
                dx_q   <= dx_in;
                src_q  <= src_in;
            end
            if (state_q == ST_PREP)     cnt_q <= '0;
            else if (state_q == ST_RUN) cnt_q <= cnt_q + CW'(1);
        end
    end

    // ---------------- sign conditioning ----------------
    always_comb begin
        a_ext = eff_wide ? ax_q  : {{HW{is_signed & ax_q[HW-1]}},  ax_q[HW-1:0]};
        s_ext = eff_wide ? src_q : {{HW{is_signed & src_q[HW-1]}}, src_q[HW-1:0]};
        a_neg = is_signed & a_ext[DW-1];
        s_neg = is_signed & s_ext[DW-1];
        a_mag = a_neg ? -a_ext : a_ext;
        s_mag = s_neg ? -s_ext : s_ext;

        if (is_aam)        n_ext = {{(PW-HW){1'b0}}, ax_q[HW-1:0]};
        else if (eff_wide) n_ext = {dx_q, ax_q};
        else               n_ext = {{DW{is_signed & ax_q[DW-1]}}, ax_q};
        n_neg = is_signed & n_ext[PW-1];
        n_mag = n_neg ? -n_ext : n_ext;

        div_den = is_aam ? DW'(RADIX) : s_mag;
        if (eff_wide) begin
            div_hi = n_mag[PW-1:DW];
            div_lo = n_mag[DW-1:0];
        end else begin
            div_hi = {{HW{1'b0}}, n_mag[DW-1:HW]};
            div_lo = {n_mag[HW-1:0], {HW{1'b0}}};
        end
        // quotient fits n bits exactly when the upper half is below the divisor
        pre_ovf = div_hi >= div_den;

        mul_a = is_aad ? {{HW{1'b0}}, ax_q[DW-1:HW]} : a_mag;
        mul_b = is_aad ? DW'(RADIX) : s_mag;
    end

    mdu_shift_mul #(.W(DW)) u_mul (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (state_q == ST_PREP),
        .step    (state_q == ST_RUN),
        .mcand   (mul_a),
        .mplier  (mul_b),
        .product (prod_mag)
    );

    mdu_shift_div #(.W(DW)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (state_q == ST_PREP),
        .step   (state_q == ST_RUN),
        .num_hi (div_hi),
        .num_lo (div_lo),
        .den    (div_den),
        .quo    (quo_mag),
        .rem    (rem_mag)
    );

    // ---------------- result mapping ----------------
    always_comb begin
        p_val    = (a_neg ^ s_neg) ? -prod_mag : prod_mag;
        q_val    = (n_neg ^ s_neg) ? -quo_mag : quo_mag;
        r_val    = n_neg ? -rem_mag : rem_mag;
        q_lim    = eff_wide ? {1'b0, {(DW-1){1'b1}}} : {{(DW-HW+1){1'b0}}, {(HW-1){1'b1}}};
        div_trap = pre_ovf | (is_signed & (quo_mag > q_lim));
        mul_big  = eff_wide ? (p_val[PW-1:DW] != {DW{is_signed & p_val[DW-1]}})
                            : (p_val[DW-1:HW] != {HW{is_signed & p_val[HW-1]}});
        aad_sum  = prod_mag[HW-1:0] + ax_q[HW-1:0];

        nx_ax   = ax_q;
        nx_dx   = dx_q;
        nx_flag = 1'b0;
        nx_trap = 1'b0;
        unique case (op_q)
            OP_MULU, OP_MULS: begin
                nx_ax   = p_val[DW-1:0];
                nx_dx   = eff_wide ? p_val[PW-1:DW] : dx_q;
                nx_flag = mul_big;
            end
            OP_DIVU, OP_DIVS: begin
                nx_trap = div_trap;
                if (eff_wide) begin
                    nx_ax = q_val;
                    nx_dx = r_val;
                end else begin
                    nx_ax = {r_val[HW-1:0], q_val[HW-1:0]};
                end
            end
            OP_AAM:  nx_ax = {quo_mag[HW-1:0], rem_mag[HW-1:0]};
            OP_AAD:  nx_ax = {{HW{1'b0}}, aad_sum};
            default: nx_ax = ax_q;
        endcase
        if (nx_trap) begin
            nx_ax   = ax_q;
            nx_dx   = dx_q;
            nx_flag = 1'b0;
        end
    end

    // ---------------- output process ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_ax  <= '0;
            res_dx  <= '0;
            flag_cf <= 1'b0;
            flag_of <= 1'b0;
            trap_q  <= 1'b0;
        end else if (state_q == ST_FIX) begin
            res_ax  <= nx_ax;
            res_dx  <= nx_dx;
            flag_cf <= nx_flag;
            flag_of <= nx_flag;
            trap_q  <= nx_trap;
        end
    end

    assign done = (state_q == ST_DONE);
    assign trap = done & trap_q;

    // ---------------- assertions ----------------
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R3
    AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n) (state_q == ST_RUN) |-> (cnt_q < run_len)); // R3
    AST_TRAP_ONLY_DONE: assert property (@(posedge clk) disable iff (!rst_n) trap |-> done); // R10
    AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n) (state_q != ST_IDLE) |=> (state_q != ST_PREP)); // R14
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (state_q != ST_FIX) |=> ($stable(res_ax) && $stable(res_dx))); // R14
    AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n) (state_q == ST_FIX && is_div && !pre_ovf) |-> (rem_mag < div_den)); // R9
    AST_DIV_FLAGS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (done && is_div) |-> (!flag_cf && !flag_of)); // R7
endmodule

// File: tb/mdu_trap_unit_tb.sv
module mdu_trap_unit_tb;
    timeunit 1ns; timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op_sel = 3'd0;
    logic        wide = 1'b0;
    logic [15:0] ax_in = '0, dx_in = '0, src_in = '0;
    logic [15:0] res_ax, res_dx;
    logic        flag_cf, flag_of, done, trap;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    mdu_trap_unit u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel), .wide(wide),
        .ax_in(ax_in), .dx_in(dx_in), .src_in(src_in),
        .res_ax(res_ax), .res_dx(res_dx), .flag_cf(flag_cf), .flag_of(flag_of),
        .done(done), .trap(trap)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic void model(input logic [2:0] op, input logic w,
                                  input logic [15:0] ax, input logic [15:0] dx, input logic [15:0] src,
                                  output logic [15:0] eax, output logic [15:0] edx,
                                  output logic ef, output logic etr);
        longint p, n, d, q, r;
        eax = ax; edx = dx; ef = 1'b0; etr = 1'b0;
        case (op)
            3'd0: begin
                if (!w) begin p = longint'(ax[7:0]) * longint'(src[7:0]); eax = p[15:0]; ef = p > 255; end
                else begin p = longint'(ax) * longint'(src); eax = p[15:0]; edx = p[31:16]; ef = p > 65535; end
            end
            3'd1: begin
                if (!w) begin
                    p = longint'($signed(ax[7:0])) * longint'($signed(src[7:0]));
                    eax = p[15:0]; ef = (p > 127) || (p < -128);
                end else begin
                    p = longint'($signed(ax)) * longint'($signed(src));
                    eax = p[15:0]; edx = p[31:16]; ef = (p > 32767) || (p < -32768);
                end
            end
            3'd2: begin
                if (!w) begin n = longint'(ax); d = longint'(src[7:0]); end
                else    begin n = longint'({dx, ax}); d = longint'(src); end
                if (d == 0) etr = 1'b1;
                else begin
                    q = n / d; r = n % d;
                    if (q > (w ? 65535 : 255)) etr = 1'b1;
                    else if (!w) eax = {r[7:0], q[7:0]};
                    else begin eax = q[15:0]; edx = r[15:0]; end
                end
            end
            3'd3: begin
                if (!w) begin n = longint'($signed(ax)); d = longint'($signed(src[7:0])); end
                else    begin n = longint'($signed({dx, ax})); d = longint'($signed(src)); end
                if (d == 0) etr = 1'b1;
                else begin
                    q = n / d; r = n % d;
                    if (q > (w ? 32767 : 127) || q < (w ? -32767 : -127)) etr = 1'b1;
                    else if (!w) eax = {r[7:0], q[7:0]};
                    else begin eax = q[15:0]; edx = r[15:0]; end
                end
            end
            3'd4: begin q = longint'(ax[7:0]) / 10; r = longint'(ax[7:0]) % 10; eax = {q[7:0], r[7:0]}; end
            3'd5: begin p = longint'(ax[15:8]) * 10 + longint'(ax[7:0]); eax = {8'h00, p[7:0]}; end
            default: ;
        endcase
    endfunction

    // Entered and left at a negedge. poke: lat value at which a stray start is pulsed
    // mid-run (-1 none); poke_done: pulse start in the done cycle itself.
    task automatic run_op(input logic [2:0] op, input logic w, input logic [15:0] ax,
                          input logic [15:0] dx, input logic [15:0] src, input string req,
                          input int poke, input bit poke_done);
        logic [15:0] eax, edx;
        logic ef, etr;
        int lat, steps, extra;
        model(op, w, ax, dx, src, eax, edx, ef, etr);
        steps = (w && op <= 3'd3) ? 16 : 8;
        start = 1'b1; op_sel = op; wide = w; ax_in = ax; dx_in = dx; src_in = src;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 60) begin
            ax_in = 16'($urandom); dx_in = 16'($urandom); src_in = 16'($urandom);
            op_sel = 3'($urandom_range(0, 5)); wide = 1'($urandom_range(0, 1));
            start = (lat == poke);
            @(posedge clk);
            lat++;
            @(negedge clk);
            start = 1'b0;
        end
        chk({req, "/R3"}, "latency", 32'(lat), 32'(steps + 2));
        chk(req, "res_ax", {16'h0, res_ax}, {16'h0, eax});
        chk(req, "res_dx", {16'h0, res_dx}, {16'h0, edx});
        chk(req, "flag_cf", {31'h0, flag_cf}, {31'h0, ef});
        chk(req, "flag_of", {31'h0, flag_of}, {31'h0, ef});
        chk(req, "trap", {31'h0, trap}, {31'h0, etr});
        if (poke_done) begin
            start = 1'b1; op_sel = 3'd0; wide = 1'b1; ax_in = 16'h1234; src_in = 16'h0003;
        end
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        chk("R3", "done after pulse", {31'h0, done}, 32'h0);
        if (poke_done) begin
            extra = 0;
            for (int i = 0; i < 24; i++) begin
                if (done) extra++;
                @(posedge clk);
                @(negedge clk);
            end
            chk("R14", "done after start in done cycle", 32'(extra), 32'h0);
            chk("R14", "res_ax held", {16'h0, res_ax}, {16'h0, eax});
        end
    endtask

    function automatic string req_of(input logic [2:0] op, input logic w);
        case (op)
            3'd0: return w ? "R5/R6" : "R4/R6";
            3'd1: return w ? "R5/R6" : "R4/R6";
            3'd2: return w ? "R8/R10" : "R7/R10";
            3'd3: return w ? "R8/R9/R11" : "R7/R9/R11";
            3'd4: return "R12";
            default: return "R13";
        endcase
    endfunction

    initial begin
        #1200000;
        errors++;
        $display("FAIL R3 watchdog: actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] hold_ax;
        int seen;
        void'($urandom(32'd424242));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1", "res_ax", {16'h0, res_ax}, 32'h0);
        chk("R1", "res_dx", {16'h0, res_dx}, 32'h0);
        chk("R1", "flags", {30'h0, flag_cf, flag_of}, 32'h0);
        chk("R1", "done/trap", {30'h0, done, trap}, 32'h0);

        // directed multiplies
        run_op(3'd0, 1'b0, 16'h00FF, 16'h5555, 16'h00FF, "R4/R6", -1, 1'b0);
        run_op(3'd0, 1'b0, 16'h0010, 16'h5555, 16'h000F, "R4/R6", -1, 1'b0);
        run_op(3'd1, 1'b0, 16'h0080, 16'h0000, 16'h0080, "R4/R6", -1, 1'b0);
        run_op(3'd1, 1'b0, 16'h00FF, 16'h0000, 16'h0001, "R4/R6", -1, 1'b0);
        run_op(3'd0, 1'b1, 16'hFFFF, 16'h0000, 16'hFFFF, "R5/R6", -1, 1'b0);
        run_op(3'd1, 1'b1, 16'h8000, 16'h0000, 16'hFFFF, "R5/R6", -1, 1'b0);
        run_op(3'd1, 1'b1, 16'hFFFE, 16'h0000, 16'h0003, "R5/R6", -1, 1'b0);
        // directed divides
        run_op(3'd2, 1'b0, 16'h00FF, 16'hAAAA, 16'h0001, "R7", -1, 1'b0);
        run_op(3'd2, 1'b0, 16'h0100, 16'hAAAA, 16'h0001, "R10", -1, 1'b0);
        run_op(3'd2, 1'b1, 16'h0000, 16'h0001, 16'h0000, "R10", -1, 1'b0);
        run_op(3'd2, 1'b1, 16'h5678, 16'h0012, 16'h1234, "R8", -1, 1'b0);
        run_op(3'd3, 1'b0, 16'hFFF9, 16'h0000, 16'h0002, "R9", -1, 1'b0);
        run_op(3'd3, 1'b0, 16'hFF81, 16'h0000, 16'h0001, "R11", -1, 1'b0);
        run_op(3'd3, 1'b0, 16'hFF80, 16'h0000, 16'h0001, "R11", -1, 1'b0);
        run_op(3'd3, 1'b1, 16'h8001, 16'hFFFF, 16'h0001, "R11", -1, 1'b0);
        run_op(3'd3, 1'b1, 16'h8000, 16'hFFFF, 16'h0001, "R11", -1, 1'b0);
        run_op(3'd3, 1'b1, 16'hFFF9, 16'hFFFF, 16'hFFFE, "R9", -1, 1'b0);
        // decimal adjust
        run_op(3'd4, 1'b1, 16'h773F, 16'h0000, 16'h0000, "R12", -1, 1'b0);
        run_op(3'd5, 1'b0, 16'h0705, 16'h0000, 16'h9999, "R13", -1, 1'b0);
        run_op(3'd5, 1'b1, 16'hFFFF, 16'h0000, 16'h0001, "R13", -1, 1'b0);
        // busy interactions
        run_op(3'd2, 1'b1, 16'h4321, 16'h0003, 16'h0007, "R14", 5, 1'b0);
        run_op(3'd1, 1'b1, 16'h0123, 16'h0000, 16'hFF00, "R14", -1, 1'b1);

        // R2 reserved codes 6 and 7 ignored
        for (int c = 6; c < 8; c++) begin
            hold_ax = res_ax;
            start = 1'b1; op_sel = 3'(c); wide = 1'b0; ax_in = 16'h0203; src_in = 16'h0004;
            @(posedge clk);
            @(negedge clk);
            start = 1'b0;
            seen = 0;
            for (int i = 0; i < 24; i++) begin
                if (done) seen++;
                @(posedge clk);
                @(negedge clk);
            end
            chk("R2", "done on reserved code", 32'(seen), 32'h0);
            chk("R2", "res_ax after reserved code", {16'h0, res_ax}, {16'h0, hold_ax});
        end

        // constrained random
        for (int k = 0; k < 400; k++) begin
            logic [2:0]  op;
            logic        w;
            logic [15:0] ax, dx, src;
            op  = 3'($urandom_range(0, 5));
            w   = 1'($urandom_range(0, 1));
            ax  = 16'($urandom);
            dx  = 16'($urandom);
            src = 16'($urandom);
            if ((op == 3'd2 || op == 3'd3) && $urandom_range(0, 3) != 0) begin
                if (w) dx = (src == 16'h0) ? 16'h0 : 16'($urandom_range(0, 32'(src) - 1) >> 1);
                else   ax[15:8] = (src[7:0] == 8'h0) ? 8'h0 : 8'($urandom_range(0, 32'(src[7:0]) - 1) >> 1);
            end
            run_op(op, w, ax, dx, src, req_of(op, w), -1, 1'b0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule